// File: doc/BRIEF.md
# Framed Serial Write Receiver

This block is the write side of a serial slave port. An external master frames each transfer by pulling an active-low sync line low, then clocks 24 bits in, most significant first, with data sampled on every falling edge of the serial clock. When sync returns high, the receiver decides whether the frame was good. A good frame has had exactly 24 falling edges. It crosses into the system clock domain and appears as a one-cycle write strobe carrying a 2-bit mode, a 6-bit address and a data field.

A frame cut short before its 24th edge is thrown away without trace. A frame that received more than 24 edges is also discarded, and it raises a sticky error flag. A parameter picks between two data formats: a 16-bit data field, or a 14-bit field whose two lowest frame bits are reserved. The serial clock may run all the time or only during frames. Edges seen while sync is high do nothing.

Top module: `serial_write_rx`

## Requirements
- R1: While rst_n is low, and after it is released with no frame yet committed, wr_valid is 0, overrun_err is 0, and wr_mode, wr_addr and wr_data are all 0.
- R2: A frame with exactly 24 falling sclk edges while sync_n is low, followed by sync_n rising, produces exactly one wr_valid pulse. The first bit shifted in is frame bit 23. wr_mode is frame bits 23:22 and wr_addr is frame bits 21:16.
- R3: With NARROW = 0, wr_data equals frame bits 15:0.
- R4: With NARROW = 1, wr_data equals {2'b00, frame bits 15:2}. Frame bits 1:0 are reserved and their values have no effect on any output.
- R5: If sync_n rises after fewer than 24 falling edges, no pulse is produced, and wr_mode, wr_addr, wr_data and overrun_err keep their previous values.
- R6: If sync_n rises after more than 24 falling edges, no pulse is produced and overrun_err is set. It stays set until rst_n is taken low.
- R7: The commit happens on the rising edge of sync_n and not at the 24th edge. While sync_n stays low after 24 edges, no pulse appears.
- R8: Falling sclk edges while sync_n is high are ignored. A frame embedded in a continuously running serial clock commits exactly as it would with a gated clock.
- R9: wr_valid is high for exactly one system clock cycle per committed frame. wr_mode, wr_addr and wr_data change only in a cycle where wr_valid is high.
- R10: The wr_valid pulse is seen within 4 system clock rising edges after sync_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; synchronous for the system-domain registers, asynchronous for the commit register |
| sclk | input | 1 | Serial clock; data is sampled on its falling edge |
| sync_n | input | 1 | Active-low frame enable; a good frame commits on its rising edge |
| sdi | input | 1 | Serial data in, most significant bit first |
| wr_valid | output | 1 | One-cycle strobe for each committed frame |
| wr_mode | output | 2 | Mode field of the last committed frame |
| wr_addr | output | 6 | Address field of the last committed frame |
| wr_data | output | 16 | Data field of the last committed frame, right-aligned |
| overrun_err | output | 1 | Sticky flag: a frame with more than 24 edges was seen |

## Verification
The hardest situations to reach are the edge counts that sit right next to 24. A frame one edge short, or one edge too long, must leave the outputs unchanged and differ from a good frame only in the error flag. The stimulus draws edge counts at random from short, exact and long ranges. It adds directed frames of 23, 24 and 25 edges, and a frame embedded in a free-running serial clock. A second instance built in the narrow format receives the same frames, so the reserved bits are driven with random values and must never show up. One frame holds sync low after its 24th edge to show that nothing commits until sync rises.

// File: rtl/swr_pkg.sv
`timescale 1ns/1ps
// Shared sizes and types for the framed serial write receiver.
// Assumes a fixed 24-bit frame: mode on top, then address, then data.
package swr_pkg;
    localparam int FRAME_W = 24;
    localparam int MODE_W  = 2;
    localparam int ADDR_W  = 6;
    localparam int DATA_W  = FRAME_W - MODE_W - ADDR_W;
    localparam int CNT_W   = $clog2(FRAME_W + 2);

    typedef logic [FRAME_W-1:0] frame_t;
    typedef logic [CNT_W-1:0]   edge_cnt_t;
endpackage

// File: rtl/swr_shift.sv
`timescale 1ns/1ps
// Serial-domain capture: shifts sdi in on falling sclk edges while sync_n is low,
// and counts edges up to one past a full frame (saturating) so that the commit
// logic can tell short, exact and long frames apart.
// Assumes sync_n high clears the count; edges while sync_n is high are ignored.
module swr_shift
    import swr_pkg::*;
(
    input  logic      sclk,
    input  logic      sync_n,
    input  logic      sdi,
    output frame_t    frame_q,
    output edge_cnt_t cnt_q
);
    localparam edge_cnt_t CNT_FULL = edge_cnt_t'(FRAME_W);
    localparam edge_cnt_t CNT_SAT  = edge_cnt_t'(FRAME_W + 1);

    // Edge counter: held at zero outside a frame, saturates after a long frame.
    always_ff @(negedge sclk or posedge sync_n) begin
        if (sync_n) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_SAT) begin
            cnt_q <= cnt_q + edge_cnt_t'(1);
        end
    end

    // Shift register: takes only the first FRAME_W bits of a frame, MSB first.
    always_ff @(negedge sclk) begin
        if (!sync_n && (cnt_q < CNT_FULL)) begin
            frame_q <= {frame_q[FRAME_W-2:0], sdi};
        end
    end
endmodule

// File: rtl/swr_commit.sv
`timescale 1ns/1ps
// Commit stage, clocked by the rising edge of sync_n: latches an exact-length frame
// into a holding register and flips the write toggle, or flips the error toggle
// for an over-long frame. Short frames leave everything untouched.
// Assumes the holding register stays stable until the system domain has sampled it.
module swr_commit
    import swr_pkg::*;
(
    input  logic      sync_n,
    input  logic      rst_n,
    input  frame_t    frame_d,
    input  edge_cnt_t cnt_d,
    output frame_t    hold_q,
    output logic      wr_tog_q,
    output logic      err_tog_q
);
    localparam edge_cnt_t CNT_FULL = edge_cnt_t'(FRAME_W);

    // Frame judgement at the end of the frame; the count is read before it clears.
    always_ff @(posedge sync_n or negedge rst_n) begin
        if (!rst_n) begin
            hold_q    <= '0;
            wr_tog_q  <= 1'b0;
            err_tog_q <= 1'b0;
        end else if (cnt_d == CNT_FULL) begin
            hold_q    <= frame_d;
            wr_tog_q  <= ~wr_tog_q;
        end else if (cnt_d > CNT_FULL) begin
            err_tog_q <= ~err_tog_q;
        end
    end
endmodule

// File: rtl/swr_toggle_sync.sv
`timescale 1ns/1ps
// Toggle synchronizer: carries a level toggle into clk through STAGES flops and
// turns each change into a one-cycle pulse.
// Assumes the toggle changes at most once per STAGES+1 clk cycles.
module swr_toggle_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_in,
    output logic pulse_out
);
    logic [STAGES:0] pipe_q;

    // Synchronizer chain plus one extra flop for edge detection.
    generate
        for (genvar g = 0; g <= STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pipe_q[g] <= 1'b0;
                end else begin
                    pipe_q[g] <= (g == 0) ? tog_in : pipe_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign pulse_out = pipe_q[STAGES] ^ pipe_q[STAGES-1];
endmodule

// File: rtl/serial_write_rx.sv
`timescale 1ns/1ps
// Framed serial write receiver: captures 24-bit frames on falling sclk edges,
// commits exact-length frames on the rising edge of sync_n, and presents them in
// the clk domain as a one-cycle strobe with mode, address and data fields.
// NARROW selects the 14-bit data format, whose two lowest frame bits are reserved.
// Assumes consecutive frame ends are at least four clk cycles apart.
module serial_write_rx
    import swr_pkg::*;
#(
    parameter int NARROW      = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sync_n,
    input  logic              sdi,
    output logic              wr_valid,
    output logic [MODE_W-1:0] wr_mode,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              overrun_err
);
    localparam int RSVD_BITS = (NARROW != 0) ? 2 : 0;

    frame_t    frame_s;
    edge_cnt_t cnt_s;
    frame_t    hold_s;
    logic      wr_tog_s, err_tog_s;
    logic      wr_pulse, err_pulse;
    logic [DATA_W-1:0] data_field;

    swr_shift u_shift (
        .sclk    (sclk),
        .sync_n  (sync_n),
        .sdi     (sdi),
        .frame_q (frame_s),
        .cnt_q   (cnt_s)
    );

    swr_commit u_commit (
        .sync_n    (sync_n),
        .rst_n     (rst_n),
        .frame_d   (frame_s),
        .cnt_d     (cnt_s),
        .hold_q    (hold_s),
        .wr_tog_q  (wr_tog_s),
        .err_tog_q (err_tog_s)
    );

    swr_toggle_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .tog_in    (wr_tog_s),
        .pulse_out (wr_pulse)
    );

    swr_toggle_sync #(.STAGES(SYNC_STAGES)) u_err_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .tog_in    (err_tog_s),
        .pulse_out (err_pulse)
    );

    // Data field: the reserved low bits fall off the right in the narrow format.
    assign data_field = hold_s[DATA_W-1:0] >> RSVD_BITS;

    // Output registers: strobe, field capture and sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid    <= 1'b0;
            wr_mode     <= '0;
            wr_addr     <= '0;
            wr_data     <= '0;
            overrun_err <= 1'b0;
        end else begin
            wr_valid <= wr_pulse;
            if (wr_pulse) begin
                wr_mode <= hold_s[FRAME_W-1 -: MODE_W];
                wr_addr <= hold_s[DATA_W +: ADDR_W];
                wr_data <= data_field;
            end
            if (err_pulse) begin
                overrun_err <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/swr_checker.sv
`timescale 1ns/1ps
// Property checker for serial_write_rx, attached by bind below.
// Assumes the ports of the receiver and its NARROW setting.
module swr_checker
    import swr_pkg::*;
#(
    parameter int NARROW = 0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [MODE_W-1:0] wr_mode,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              overrun_err
);
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid); // R9

    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({wr_mode, wr_addr, wr_data}) |-> wr_valid); // R9

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_err |=> overrun_err); // R6

    AST_RSVD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && (NARROW != 0)) |-> (wr_data[DATA_W-1 -: 2] == 2'b00)); // R4
endmodule

bind serial_write_rx swr_checker #(.NARROW(NARROW)) u_swr_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid    (wr_valid),
    .wr_mode     (wr_mode),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .overrun_err (overrun_err)
);

// File: tb/serial_write_rx_tb_top.sv
`timescale 1ns/1ps
// Bench: drives the same serial frames into a wide-format and a narrow-format
// receiver and compares their outputs with values computed from the frame word.
module serial_write_rx_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1;
    logic sync_n = 1'b1;
    logic sdi = 1'b0;

    logic        w_valid, n_valid, w_err, n_err;
    logic [1:0]  w_mode, n_mode;
    logic [5:0]  w_addr, n_addr;
    logic [15:0] w_data, n_data;

    int checks = 0;
    int failures = 0;
    int w_pulses = 0, n_pulses = 0;
    int dbl_pulse = 0;
    logic w_prev = 1'b0, n_prev = 1'b0;
    int exp_pulses = 0;
    logic exp_err = 1'b0;
    logic [23:0] exp_word = '0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    serial_write_rx #(.NARROW(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .sdi(sdi),
        .wr_valid(w_valid), .wr_mode(w_mode), .wr_addr(w_addr),
        .wr_data(w_data), .overrun_err(w_err)
    );

    serial_write_rx #(.NARROW(1)) dut_n_i (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .sdi(sdi),
        .wr_valid(n_valid), .wr_mode(n_mode), .wr_addr(n_addr),
        .wr_data(n_data), .overrun_err(n_err)
    );

    // Pulse monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (w_valid) w_pulses++;
        if (n_valid) n_pulses++;
        if ((w_valid && w_prev) || (n_valid && n_prev)) dbl_pulse++;
        w_prev = w_valid;
        n_prev = n_valid;
    end

    function automatic logic [15:0] exp_wide(input logic [23:0] w);
        return w[15:0];
    endfunction

    function automatic logic [15:0] exp_narrow(input logic [23:0] w);
        return {2'b00, w[15:2]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One serial clock pulse with sdi set up while sclk is high.
    task automatic sclk_pulse(input logic bitv);
        sdi = bitv;
        #20 sclk = 1'b0;
        #20 sclk = 1'b1;
    endtask

    // Sends a frame of nedges falling edges; extra edges carry random bits.
    // With cont set, free-running edges surround the frame while sync_n is high.
    task automatic send_frame(input logic [23:0] w, input int nedges, input bit cont,
                              input bit hold_low);
        if (cont) for (int i = 0; i < 5; i++) sclk_pulse(1'($urandom));
        #15 sync_n = 1'b0;
        #15;
        for (int i = 0; i < nedges; i++) sclk_pulse((i < 24) ? w[23-i] : 1'($urandom));
        if (hold_low) begin
            repeat (8) @(negedge clk);
            chk("R7 no commit before sync rise", 32'(w_pulses), 32'(exp_pulses));
        end
        #15 sync_n = 1'b1;
        if (cont) for (int i = 0; i < 5; i++) sclk_pulse(1'($urandom));
        if (nedges == 24) begin
            exp_pulses++;
            exp_word = w;
        end else if (nedges > 24) begin
            exp_err = 1'b1;
        end
    endtask

    task automatic check_outputs(input string tag);
        chk({tag, " R2 wide pulses"}, 32'(w_pulses), 32'(exp_pulses));
        chk({tag, " R2 narrow pulses"}, 32'(n_pulses), 32'(exp_pulses));
        chk({tag, " R2 mode"}, 32'(w_mode), 32'(exp_word[23:22]));
        chk({tag, " R2 addr"}, 32'(w_addr), 32'(exp_word[21:16]));
        chk({tag, " R3 wide data"}, 32'(w_data), 32'(exp_wide(exp_word)));
        chk({tag, " R4 narrow data"}, 32'(n_data), 32'(exp_narrow(exp_word)));
        chk({tag, " R4 narrow addr"}, 32'(n_addr), 32'(exp_word[21:16]));
        chk({tag, " R6 wide err"}, 32'(w_err), 32'(exp_err));
        chk({tag, " R6 narrow err"}, 32'(n_err), 32'(exp_err));
    endtask

    // Frame end: the pulse must be visible after the fourth rising edge (R10).
    task automatic finish_frame(input string tag);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk({tag, " R10 latency"}, 32'(w_pulses), 32'(exp_pulses));
        repeat (4) @(negedge clk);
        check_outputs(tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 valid in reset", 32'(w_valid), 0);
        chk("R1 err in reset", 32'(w_err | n_err), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        exp_err = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        chk("R1 fields after reset", 32'({w_mode, w_addr, w_data}), 0);
        chk("R1 narrow data after reset", 32'(n_data), 0);

        // Directed: exact frame, gated clock; reserved bits set.
        send_frame(24'hA5_C3_7F, 24, 1'b0, 1'b0);
        finish_frame("dir24");
        // Directed: one edge short must change nothing (R5).
        send_frame(24'h3F_FF_FF, 23, 1'b0, 1'b0);
        finish_frame("R5 short23");
        // Directed: reserved bits differ only; narrow data unchanged in value (R4).
        send_frame(24'hA5_C3_7C, 24, 1'b0, 1'b0);
        finish_frame("R4 rsvd");
        // Directed: hold sync low after 24 edges (R7).
        send_frame(24'h5A_12_34, 24, 1'b0, 1'b1);
        finish_frame("R7 hold");
        // Directed: continuous clock around the frame (R8).
        send_frame(24'hC7_9E_01, 24, 1'b1, 1'b0);
        finish_frame("R8 cont");
        // Directed: one edge too many sets the sticky error (R6).
        send_frame(24'h00_00_01, 25, 1'b0, 1'b0);
        finish_frame("R6 long25");
        send_frame(24'h81_40_02, 24, 1'b0, 1'b0);
        finish_frame("R6 sticky");

        // Random mix of short, exact and long frames, gated or continuous.
        for (int k = 0; k < 30; k++) begin
            int sel = int'($urandom_range(0, 9));
            int n = (sel < 6) ? 24 : (sel < 8) ? int'($urandom_range(1, 23))
                                                : int'($urandom_range(25, 30));
            send_frame(24'($urandom), n, 1'($urandom), 1'b0);
            finish_frame("rnd");
        end

        chk("R9 single-cycle pulses", 32'(dbl_pulse), 0);

        // Reset clears the sticky error (R6, R1).
        send_frame(24'h11_11_11, 27, 1'b0, 1'b0);
        finish_frame("R6 pre-reset");
        do_reset();
        chk("R6 err cleared by reset", 32'(w_err | n_err), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        #4000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule